// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This unit sits beside the command sequencer of a serial memory. It holds the status byte: the write enable latch, two block-protect bits, the enable bit for the hardware write-protect pin, and a busy flag for the self-timed program cycle. When chip select rises, the sequencer presents one commit strobe. With the strobe it gives the opcode, the target address, the byte that a status write would load, and a flag that says the frame ended on a valid bit boundary. The unit decides in that cycle whether the command may run. One cycle later it answers with a start pulse and an operation kind, or with a reject pulse. The sequencer runs the timed cycle and reports its end on a done strobe. The status byte is always available for the shifter that serves status reads.

The unit has no back-pressure. The commit strobe and the done strobe are single-cycle control pulses that are always accepted. While a cycle is in flight, the unit filters out commits itself, so the sequencer never has to hold a request. The status-write bits are plain registers that clear on reset. Serial shifting is handled elsewhere.

Top module: `sr_protect_unit`

## Requirements
- R1: `status_o` has WPEN in bit 7, BP1 in bit 3, BP0 in bit 2, WEL in bit 1 and WIP in bit 0. Bits 6 to 4 always read 0. After reset the byte is 00h.
- R2: A commit of opcode 06h with `cmd_len_ok_i`=1 sets WEL. Opcode 04h clears WEL. Both work for any value of WPEN and of `wp_n_i`.
- R3: When WEL is 0, a write (02h), page erase (42h), sector erase (D8h), chip erase (C7h) or status write (01h) is rejected.
- R4: A write, page erase or sector erase is rejected when its address is protected. Protection uses the quarter given by the top two address bits. BP=01 protects quarter 3, BP=10 protects quarters 2 and 3, BP=11 protects all quarters, and BP=00 protects none.
- R5: A chip erase is rejected when either BP bit is 1, whatever the address.
- R6: A status write is rejected when WPEN=1 and `wp_n_i`=0. When WPEN=0 the pin has no effect. A granted status write loads WPEN from data bit 7 and BP from data bits 3:2, and ignores the other data bits.
- R7: A granted command raises `start_o` for one cycle, one cycle after the commit. `kind_o` is 0 for write, 1 for page erase, 2 for sector erase, 3 for chip erase and 4 for status write. WIP reads 1 from that cycle until the cycle after `cycle_done_i`. At that point both WIP and WEL read 0.
- R8: While WIP is 1, every commit is ignored: no pulse is produced and no status bit changes. A change on `wp_n_i` during the cycle does not affect it.
- R9: A refused command raises `reject_o` for one cycle, one cycle after the commit, and leaves every status bit unchanged.
- R10: A commit with `cmd_len_ok_i`=0 has no effect. So does a commit of any opcode other than those listed in R2 and R3. Neither produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n_i | input | 1 | Hardware write-protect pin, low means protect |
| cmd_commit_i | input | 1 | One-cycle strobe at the end of a command frame |
| cmd_len_ok_i | input | 1 | Frame ended on its valid bit boundary |
| cmd_op_i | input | 8 | Opcode of the frame |
| cmd_addr_i | input | ADDR_W | Target byte address |
| cmd_data_i | input | 8 | Byte offered to a status write |
| cycle_done_i | input | 1 | Self-timed cycle finished |
| status_o | output | 8 | Status byte |
| start_o | output | 1 | Command granted, pulse |
| reject_o | output | 1 | Command refused, pulse |
| kind_o | output | 3 | Kind of the granted or refused command |

## Verification
A commit driven in one cycle yields `start_o`, `reject_o`, `kind_o` and the updated status byte all at the next clock edge. A done strobe clears WIP and WEL at the edge that samples it. The bench therefore drives each strobe for exactly one cycle on a falling edge. It compares every output on the following falling edge against a bench-side model of the status state. That model is advanced in step with the same stimulus, so each check sits exactly one register stage after its cause.

// File: rtl/sr_protect_pkg.sv
package sr_protect_pkg;

  localparam logic [7:0] OPC_WRITE  = 8'h02;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_WRDI   = 8'h04;
  localparam logic [7:0] OPC_WRSR   = 8'h01;
  localparam logic [7:0] OPC_PERASE = 8'h42;
  localparam logic [7:0] OPC_SERASE = 8'hD8;
  localparam logic [7:0] OPC_CERASE = 8'hC7;

  typedef enum logic [2:0] {
    KIND_WRITE  = 3'd0,
    KIND_PERASE = 3'd1,
    KIND_SERASE = 3'd2,
    KIND_CERASE = 3'd3,
    KIND_SRW    = 3'd4
  } op_kind_e;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
    logic       wel;
    logic       wip;
  } sr_state_t;

  // status byte image: WPEN, three zero bits, BP1, BP0, WEL, WIP
  function automatic logic [7:0] pack_status(sr_state_t s);
    return {s.wpen, 3'b000, s.bp, s.wel, s.wip};
  endfunction

endpackage

// File: rtl/wp_region_check.sv
module wp_region_check #(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int QLO = ADDR_W - 2;

  logic [1:0] quarter;
  logic       unused_low;

  assign quarter    = addr_i[ADDR_W-1:QLO];
  assign unused_low = ^addr_i[QLO-1:0];

  always_comb begin
    unique case (bp_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = (quarter == 2'b11);
      2'b10:   hit_o = quarter[1];
      default: hit_o = 1'b1;
    endcase
  end

  always_comb begin
    if (bp_i == 2'b00) assert (!hit_o) else $error("p_open_map_r4");
  end
endmodule

// File: rtl/sr_policy.sv
module sr_policy
  import sr_protect_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  sr_state_t         st_i,
  input  logic              wp_n_i,
  input  logic              commit_i,
  input  logic              len_ok_i,
  input  logic [7:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              grant_o,
  output logic              reject_o,
  output logic              sr_load_o,
  output op_kind_e          kind_o
);
  logic live;
  logic region_hit;
  logic sr_locked;

  wp_region_check #(.ADDR_W(ADDR_W)) u_region (
    .bp_i  (st_i.bp),
    .addr_i(addr_i),
    .hit_o (region_hit)
  );

  assign live      = commit_i && len_ok_i && !st_i.wip;
  assign sr_locked = st_i.wpen && !wp_n_i;

  always_comb begin
    wel_set_o = 1'b0;
    wel_clr_o = 1'b0;
    grant_o   = 1'b0;
    reject_o  = 1'b0;
    sr_load_o = 1'b0;
    kind_o    = KIND_WRITE;
    if (live) begin
      unique case (op_i)
        OPC_WREN: wel_set_o = 1'b1;
        OPC_WRDI: wel_clr_o = 1'b1;
        OPC_WRITE, OPC_PERASE, OPC_SERASE: begin
          kind_o = (op_i == OPC_WRITE)  ? KIND_WRITE :
                   (op_i == OPC_PERASE) ? KIND_PERASE : KIND_SERASE;
          if (st_i.wel && !region_hit) grant_o = 1'b1;
          else                         reject_o = 1'b1;
        end
        OPC_CERASE: begin
          kind_o = KIND_CERASE;
          if (st_i.wel && (st_i.bp == 2'b00)) grant_o = 1'b1;
          else                                reject_o = 1'b1;
        end
        OPC_WRSR: begin
          kind_o = KIND_SRW;
          if (st_i.wel && !sr_locked) begin
            grant_o   = 1'b1;
            sr_load_o = 1'b1;
          end else begin
            reject_o = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sr_regs.sv
module sr_regs
  import sr_protect_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wel_set_i,
  input  logic      wel_clr_i,
  input  logic      grant_i,
  input  logic      sr_load_i,
  input  logic [7:0] sr_data_i,
  input  logic      cycle_done_i,
  output sr_state_t st_o
);
  sr_state_t st;
  logic      finish;
  logic      unused_data;

  assign finish      = st.wip && cycle_done_i;
  assign unused_data = ^{sr_data_i[6:4], sr_data_i[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      if (sr_load_i) begin
        st.wpen <= sr_data_i[7];
        st.bp   <= sr_data_i[3:2];
      end
      if (grant_i)     st.wip <= 1'b1;
      else if (finish) st.wip <= 1'b0;
      if (finish)         st.wel <= 1'b0;
      else if (wel_set_i) st.wel <= 1'b1;
      else if (wel_clr_i) st.wel <= 1'b0;
    end
  end

  assign st_o = st;

  p_wip_needs_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.wip) |-> $past(grant_i));
  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!st.wel && !st.wip));
  p_bits_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st.wip && !cycle_done_i) |=> ($stable(st.wpen) && $stable(st.bp) && $stable(st.wel)));
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
  import sr_protect_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              cmd_commit_i,
  input  logic              cmd_len_ok_i,
  input  logic [7:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              cycle_done_i,
  output logic [7:0]        status_o,
  output logic              start_o,
  output logic              reject_o,
  output logic [2:0]        kind_o
);
  sr_state_t st;
  logic      wel_set, wel_clr, grant, reject, sr_load;
  op_kind_e  kind;

  sr_policy #(.ADDR_W(ADDR_W)) u_policy (
    .st_i     (st),
    .wp_n_i   (wp_n_i),
    .commit_i (cmd_commit_i),
    .len_ok_i (cmd_len_ok_i),
    .op_i     (cmd_op_i),
    .addr_i   (cmd_addr_i),
    .wel_set_o(wel_set),
    .wel_clr_o(wel_clr),
    .grant_o  (grant),
    .reject_o (reject),
    .sr_load_o(sr_load),
    .kind_o   (kind)
  );

  sr_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wel_set_i   (wel_set),
    .wel_clr_i   (wel_clr),
    .grant_i     (grant),
    .sr_load_i   (sr_load),
    .sr_data_i   (cmd_data_i),
    .cycle_done_i(cycle_done_i),
    .st_o        (st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o  <= 1'b0;
      reject_o <= 1'b0;
      kind_o   <= 3'd0;
    end else begin
      start_o  <= grant;
      reject_o <= reject;
      if (grant || reject) kind_o <= kind;
    end
  end

  assign status_o = pack_status(st);

  p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(status_o[1]));
  p_ce_needs_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && kind_o == 3'd3) |-> ($past(status_o[3:2]) == 2'b00));
  p_srw_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && kind_o == 3'd4) |-> !($past(status_o[7]) && !$past(wp_n_i)));
  p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> status_o[0]);
  p_no_pulse_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o || reject_o) |-> !$past(status_o[0]));
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, reject_o}));
  p_reject_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> (status_o == $past(status_o)));
endmodule

// File: tb/tb_sr_protect_unit.sv
module tb_sr_protect_unit;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b1;
  logic          commit = 1'b0;
  logic          len_ok = 1'b1;
  logic [7:0]    op = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = 8'h00;
  logic          done = 1'b0;
  logic [7:0]    status;
  logic          start, reject;
  logic [2:0]    kind;

  int checks = 0;
  int errors = 0;

  logic       m_wel = 1'b0, m_wpen = 1'b0, m_wip = 1'b0;
  logic [1:0] m_bp = 2'b00;

  always #10 clk = ~clk;

  sr_protect_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .cmd_commit_i(commit),
    .cmd_len_ok_i(len_ok), .cmd_op_i(op), .cmd_addr_i(addr),
    .cmd_data_i(data), .cycle_done_i(done), .status_o(status),
    .start_o(start), .reject_o(reject), .kind_o(kind)
  );

  function automatic logic prot(logic [1:0] bp, logic [AW-1:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1:AW-2] == 2'b11;
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_wpen, 3'b000, m_bp, m_wel, m_wip};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_status(input string tag);
    chk(status === exp_status(), tag, "status", status, exp_status());
    chk(status[6:4] === 3'b000, "R1", "unused bits", status[6:4], 0);
  endtask

  task automatic do_commit(input logic [7:0] o, input logic [AW-1:0] a,
                           input logic [7:0] d, input logic lk);
    logic es, er;
    logic [2:0] ek;
    string tag;
    es = 0; er = 0; ek = 0; tag = "R10";
    if (m_wip) tag = "R8";
    else if (!lk) tag = "R10";
    else begin
      case (o)
        8'h06: begin m_wel = 1; tag = "R2"; end
        8'h04: begin m_wel = 0; tag = "R2"; end
        8'h02, 8'h42, 8'hD8: begin
          ek = (o == 8'h02) ? 3'd0 : (o == 8'h42) ? 3'd1 : 3'd2;
          if (!m_wel) begin er = 1; tag = "R3"; end
          else if (prot(m_bp, a)) begin er = 1; tag = "R4"; end
          else begin es = 1; m_wip = 1; tag = "R7"; end
        end
        8'hC7: begin
          ek = 3'd3;
          if (!m_wel) begin er = 1; tag = "R3"; end
          else if (m_bp != 2'b00) begin er = 1; tag = "R5"; end
          else begin es = 1; m_wip = 1; tag = "R7"; end
        end
        8'h01: begin
          ek = 3'd4;
          if (!m_wel) begin er = 1; tag = "R3"; end
          else if (m_wpen && !wp_n) begin er = 1; tag = "R6"; end
          else begin es = 1; m_wip = 1; m_wpen = d[7]; m_bp = d[3:2]; tag = "R6"; end
        end
        default: tag = "R10";
      endcase
    end
    @(negedge clk);
    op = o; addr = a; data = d; len_ok = lk; commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    chk(start === es, tag, "start", start, es);
    chk(reject === er, er ? "R9" : tag, "reject", reject, er);
    if (es || er) chk(kind === ek, "R7", "kind", kind, ek);
    check_status(tag);
  endtask

  task automatic do_done();
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    if (m_wip) begin m_wip = 0; m_wel = 0; end
    check_status("R7");
    chk(start === 1'b0 && reject === 1'b0, "R7", "no pulse on done", {start, reject}, 0);
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk);
    wp_n = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops [12];
    int unsigned seed;
    seed = $urandom(32'd20240611);
    ops = '{8'h06, 8'h06, 8'h04, 8'h02, 8'h42, 8'hD8, 8'hC7, 8'h01,
            8'h03, 8'h05, 8'hAB, 8'hB9};
    repeat (3) @(negedge clk);
    check_status("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_status("R1");

    // R2 / R10: short WREN frame, then proper set and clear
    do_commit(8'h06, '0, 8'h00, 1'b0);
    do_commit(8'h06, '0, 8'h00, 1'b1);
    do_commit(8'h04, '0, 8'h00, 1'b1);
    // R3: write with WEL clear
    do_commit(8'h02, '0, 8'h00, 1'b1);
    // R7: granted write, busy, completion
    do_commit(8'h06, '0, 8'h00, 1'b1);
    do_commit(8'h02, 17'h00010, 8'h00, 1'b1);
    do_commit(8'h06, '0, 8'h00, 1'b1);     // R8 ignored while busy
    set_wp(1'b0);                           // R8 pin change mid-cycle
    do_done();
    set_wp(1'b1);
    // R6: load WPEN=1 BP=01, junk in other data bits
    do_commit(8'h06, '0, 8'h00, 1'b1);
    do_commit(8'h01, '0, 8'hF7, 1'b1);
    do_done();
    // R4 boundary: 17FFFh writable, 18000h protected
    do_commit(8'h06, '0, 8'h00, 1'b1);
    do_commit(8'hD8, 17'h18000, 8'h00, 1'b1);
    do_commit(8'h02, 17'h17FFF, 8'h00, 1'b1);
    do_done();
    // R5: chip erase with BP nonzero
    do_commit(8'h06, '0, 8'h00, 1'b1);
    do_commit(8'hC7, '0, 8'h00, 1'b1);
    // R6: locked by pin, then WP ignored after WPEN cleared
    set_wp(1'b0);
    do_commit(8'h01, '0, 8'h00, 1'b1);
    set_wp(1'b1);
    do_commit(8'h01, '0, 8'h00, 1'b1);
    do_done();
    set_wp(1'b0);
    do_commit(8'h06, '0, 8'h00, 1'b1);
    do_commit(8'h01, '0, 8'h08, 1'b1);
    do_done();
    // R2: WREN still works with pin low
    do_commit(8'h06, '0, 8'h00, 1'b1);
    do_commit(8'h04, '0, 8'h00, 1'b1);

    for (int i = 0; i < 1500; i++) begin
      logic [7:0] o;
      int unsigned r;
      r = $urandom % 20;
      if (r < 12) o = ops[r];
      else if (r < 13) o = 8'($urandom);
      else o = (r < 17) ? 8'h06 : ops[3 + ($urandom % 5)];
      if ($urandom % 4 == 0) set_wp(1'($urandom));
      do_commit(o, AW'($urandom), 8'($urandom), ($urandom % 10) != 0);
      if (m_wip && ($urandom % 3 == 0)) do_done();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule